// File: doc/BRIEF.md
# Externally clocked synchronous serial receiver

This block receives asynchronous-style framed bytes whose bit timing comes from a serial clock pin driven by the sender, not from an internal baud divider. Both the serial clock and the serial data pass through a two-stage synchroniser into the system clock domain. A rising level change of the synchronised serial clock marks a sample point. The sender is expected to change data when the serial clock falls, so data is always taken half a bit period away from its transitions. Because the serial clock is seen only once per system cycle, each half of its period must last at least one system clock. The fastest bit rate is therefore half the system clock.

Each frame has ten bit times. The receiver assembles the data byte, presents it on a holding output and raises a ready flag until software acknowledges it. It flags an overrun when a new byte arrives on top of an unread one. It flags a framing error when the stop position holds a zero. If the receiver has lost bit alignment, the sender can send a run of ten zero bits followed by idle ones. This forces the framing logic back to a known point, and later bytes line up again.

Top module: `ssrx_top`

## Requirements
- R1: After reset, `rx_byte` is 0x00 and `rdy`, `ovr` and `ferr` are all 0.
- R2: A frame is a 0 start bit, then 8 data bits with the least significant first, then a 1 stop bit. Bits are sampled when `ser_clk` rises, and the sender changes `ser_dat` while `ser_clk` is low. `rx_byte` changes only when a good frame completes.
- R3: `rdy` sets when a 1 stop bit is sampled. It clears in the cycle after `ack` is high, and otherwise holds its value.
- R4: `rdy` and `rx_byte` update on the third rising system clock edge after the `ser_clk` pin rises for the stop bit. This comes from two synchroniser stages and one output register.
- R5: Bytes are received correctly for any `ser_clk` high time and low time of at least one system clock period each, up to a bit rate of half the system clock.
- R6: If a good frame completes while `rdy` is set and `ack` is low in that cycle, `ovr` sets and the new byte replaces the old one in `rx_byte`.
- R7: A 0 sampled at the stop position sets `ferr`, leaves `rdy` and `rx_byte` unchanged, and returns the receiver at once to waiting for a start bit. The next sampled 0 then begins a new frame.
- R8: Ten consecutive sampled 0 bits abandon any frame in progress. The receiver then ignores the line until it samples a 1, after which a following byte is received correctly.
- R9: `ovr` and `ferr` stay set until `clr` is high for one cycle. `ack` does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | External serial bit clock, asynchronous |
| ser_dat | input | 1 | External serial data, asynchronous |
| ack | input | 1 | Read acknowledge; clears `rdy` |
| clr | input | 1 | Clears the sticky error flags |
| rx_byte | output | 8 | Last good received byte |
| rdy | output | 1 | A received byte is waiting to be read |
| ovr | output | 1 | Sticky overrun flag |
| ferr | output | 1 | Sticky framing-error flag |

## Verification
Byte results are due on the third rising system clock edge after the `ser_clk` pin rises for the stop bit. One directed case samples 1 ns after the second and after the third of those edges, and expects `rdy` low and then high. Flag clears from `ack` or `clr` are due on the first rising edge after the pulse. The bench drives all inputs on falling system clock edges and checks there, or 1 ns after a rising edge. Other byte checks wait two idle bit times after the frame, so they do not depend on exact latency.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;

    localparam int DATA_W    = 8;
    localparam int ZERO_RUN  = 10;
    localparam int SYNC_STG  = 2;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_IDLE,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic              good;
        logic              bad;
        logic [DATA_W-1:0] data;
    } frame_ev_t;

    function automatic logic [DATA_W-1:0] lsb_first_in(
        input logic [DATA_W-1:0] cur,
        input logic              b
    );
        return {b, cur[DATA_W-1:1]};
    endfunction

endpackage

// File: rtl/ssrx_sync.sv
module ssrx_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ssrx_edge.sv
module ssrx_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/ssrx_frame.sv
module ssrx_frame
    import ssrx_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int ZRUN = ZERO_RUN
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      smp,
    input  logic      bit_i,
    output frame_ev_t ev
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;
    localparam int ZW = $clog2(ZRUN + 1);

    rx_state_e         st;
    logic [DW-1:0]     sh;
    logic [CW-1:0]     cnt;
    logic [ZW-1:0]     zcnt;
    logic              zfire;

    assign zfire = smp && !bit_i && (zcnt == ZW'(ZRUN - 1));

    always_comb begin
        ev      = '0;
        ev.data = sh;
        ev.good = smp && (st == ST_STOP) && bit_i;
        ev.bad  = smp && (st == ST_STOP) && !bit_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            sh   <= '0;
            cnt  <= '0;
            zcnt <= '0;
        end else if (smp) begin
            if (bit_i || zfire) zcnt <= '0;
            else                zcnt <= zcnt + ZW'(1);

            if (zfire) begin
                st <= ST_HUNT;
                sh <= '0;
            end else begin
                case (st)
                    ST_HUNT: if (bit_i) st <= ST_IDLE;
                    ST_IDLE: if (!bit_i) begin
                        st  <= ST_DATA;
                        cnt <= '0;
                    end
                    ST_DATA: begin
                        sh  <= lsb_first_in(sh, bit_i);
                        cnt <= cnt + CW'(1);
                        if (cnt == CW'(DW - 1)) st <= ST_STOP;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ssrx_top.sv
module ssrx_top
    import ssrx_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int ZRUN = ZERO_RUN,
    parameter int SYNC = SYNC_STG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ser_clk,
    input  logic          ser_dat,
    input  logic          ack,
    input  logic          clr,
    output logic [DW-1:0] rx_byte,
    output logic          rdy,
    output logic          ovr,
    output logic          ferr
);
    logic [1:0] pins_s;
    logic       smp_rise;
    frame_ev_t  ev;

    ssrx_sync #(.W(2), .STAGES(SYNC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_clk, ser_dat}),
        .q   (pins_s)
    );

    ssrx_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (pins_s[1]),
        .rise (smp_rise)
    );

    ssrx_frame #(.DW(DW), .ZRUN(ZRUN)) u_frame (
        .clk   (clk),
        .rst   (rst),
        .smp   (smp_rise),
        .bit_i (pins_s[0]),
        .ev    (ev)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte <= '0;
            rdy     <= 1'b0;
            ovr     <= 1'b0;
            ferr    <= 1'b0;
        end else begin
            if (ev.good) rx_byte <= ev.data;
            rdy  <= ev.good | (rdy & ~ack);
            ovr  <= (ev.good & rdy & ~ack) | (ovr & ~clr);
            ferr <= ev.bad | (ferr & ~clr);
        end
    end
endmodule

// File: rtl/ssrx_chk.sv
module ssrx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ack,
    input logic          clr,
    input logic          smp,
    input logic [DW-1:0] rx_byte,
    input logic          rdy,
    input logic          ovr,
    input logic          ferr
);
    // R3
    ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy) |-> $past(ack));

    // R4
    ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> $past(smp));

    // R2
    data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_byte) |-> rdy);

    // R6
    ovr_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> ($past(rdy) && !$past(ack)));

    // R9
    ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ovr) |-> $past(clr));

    // R7
    ferr_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ferr) |-> $past(smp));

    // R9
    ferr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ferr) |-> $past(clr));
endmodule

bind ssrx_top ssrx_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ack     (ack),
    .clr     (clr),
    .smp     (smp_rise),
    .rx_byte (rx_byte),
    .rdy     (rdy),
    .ovr     (ovr),
    .ferr    (ferr)
);

// File: tb/test_ssrx_top.sv
module test_ssrx_top;
    localparam time CLK_PER = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b1;
    logic       ack = 1'b0;
    logic       clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rdy, ovr, ferr;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PER / 2) clk = ~clk;

    ssrx_top i_ssrx_top (
        .clk     (clk),
        .rst     (rst),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .ack     (ack),
        .clr     (clr),
        .rx_byte (rx_byte),
        .rdy     (rdy),
        .ovr     (ovr),
        .ferr    (ferr)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one bit: data changes with the falling serial clock, rises after h cycles
    task automatic send_bit(input logic b, input int h);
        ser_dat = b;
        ser_clk = 1'b0;
        repeat (h) @(negedge clk);
        ser_clk = 1'b1;
        repeat (h) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, input int h);
        send_bit(1'b0, h);
        for (int i = 0; i < 8; i++) send_bit(v[i], h);
        send_bit(1'b1, h);
    endtask

    task automatic idle(input int n, input int h);
        for (int i = 0; i < n; i++) send_bit(1'b1, h);
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rx_byte", rx_byte, 8'h00);
        check("R1 rdy", {7'd0, rdy}, 8'd0);
        check("R1 ovr", {7'd0, ovr}, 8'd0);
        check("R1 ferr", {7'd0, ferr}, 8'd0);
    endtask

    task automatic t_rates();
        int          hs[4]   = '{1, 2, 3, 5};
        logic [7:0]  vals[4] = '{8'hA5, 8'h00, 8'hFF, 8'h1E};
        for (int k = 0; k < 4; k++) begin
            send_byte(vals[k], hs[k]);
            idle(2, hs[k]);
            check("R5 data at rate", rx_byte, vals[k]);
            check("R3 rdy set", {7'd0, rdy}, 8'd1);
            check("R6 no overrun", {7'd0, ovr}, 8'd0);
            pulse_ack();
            check("R3 rdy cleared by ack", {7'd0, rdy}, 8'd0);
        end
    endtask

    task automatic t_latency();
        logic [7:0] v = 8'h6C;
        send_bit(1'b0, 4);
        for (int i = 0; i < 8; i++) send_bit(v[i], 4);
        ser_dat = 1'b1;
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        check("R4 rdy not yet after two edges", {7'd0, rdy}, 8'd0);
        @(posedge clk);
        #1;
        check("R4 rdy on third edge", {7'd0, rdy}, 8'd1);
        check("R4 data on third edge", rx_byte, v);
        @(negedge clk);
        @(negedge clk);
        idle(3, 2);
        check("R3 rdy holds without ack", {7'd0, rdy}, 8'd1);
        pulse_ack();
    endtask

    task automatic t_overrun();
        send_byte(8'h11, 2);
        idle(1, 2);
        send_byte(8'h22, 2);
        idle(2, 2);
        check("R6 overrun set", {7'd0, ovr}, 8'd1);
        check("R6 new byte replaces old", rx_byte, 8'h22);
        pulse_ack();
        check("R3 rdy cleared", {7'd0, rdy}, 8'd0);
        check("R9 ack leaves ovr", {7'd0, ovr}, 8'd1);
        pulse_clr();
        check("R9 clr clears ovr", {7'd0, ovr}, 8'd0);
    endtask

    task automatic t_ferr();
        logic [7:0] bad = 8'h81;
        logic [7:0] good = 8'h3C;
        send_bit(1'b0, 3);
        for (int i = 0; i < 8; i++) send_bit(bad[i], 3);
        send_bit(1'b0, 3);
        @(negedge clk);
        @(negedge clk);
        check("R7 ferr set", {7'd0, ferr}, 8'd1);
        check("R7 no rdy on bad stop", {7'd0, rdy}, 8'd0);
        check("R7 data unchanged", rx_byte, 8'h22);
        send_byte(good, 3);
        idle(2, 3);
        check("R7 next zero starts frame", rx_byte, good);
        check("R7 rdy after good frame", {7'd0, rdy}, 8'd1);
        pulse_ack();
        check("R9 ack leaves ferr", {7'd0, ferr}, 8'd1);
        pulse_clr();
        check("R9 clr clears ferr", {7'd0, ferr}, 8'd0);
    endtask

    task automatic t_zrun();
        send_bit(1'b0, 2);
        send_bit(1'b1, 2);
        send_bit(1'b1, 2);
        for (int i = 0; i < 10; i++) send_bit(1'b0, 2);
        idle(2, 2);
        pulse_clr();
        send_byte(8'hA5, 2);
        idle(2, 2);
        check("R8 aligned after zero run", rx_byte, 8'hA5);
        check("R8 rdy after zero run", {7'd0, rdy}, 8'd1);
        check("R8 no framing error on good byte", {7'd0, ferr}, 8'd0);
        pulse_ack();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rates();
        t_latency();
        t_overrun();
        t_ferr();
        t_zrun();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule